// File: doc/BRIEF.md
# Kernel Segment Address Translator

This block is the first stage of an address translation path. It divides the 32-bit virtual space into sixteen regions of 256 MB, chosen by the top four address bits. Software configures each region through a small register write port. A region either relocates accesses directly, by swapping in a 4-bit physical region number, or hands them on untouched to a later page-table stage.

A privilege fence applies to unprivileged (user) accesses. Such accesses may only reach virtual addresses below 0xB0000000. A user access to any of the five highest regions is refused with a fault. Privileged (kernel) accesses reach all sixteen regions.

Each accepted request produces one registered response in the next cycle. The response carries the physical address, a flag that routes the access to paging, and a fault flag.

Top module: `kseg_xlate`

## Requirements
- R1: After reset all configuration is zero, so every region is directly relocated with region number 0, and `rsp_valid` is low.
- R2: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low in the cycle after each cycle with `req_valid` low.
- R3: A region in direct mode returns `{base, req_addr[27:0]}` with `rsp_paged` low. A base equal to the region's own index (for example 4 on region 4) returns the address unchanged.
- R4: Write select 1 loads the base nibbles of regions 0 to 7, with region i at data bits 4i+3:4i. Write select 2 loads regions 8 to 15, with region 8+i at bits 4i+3:4i.
- R5: Write select 0 loads the mode word, where bit i set puts region i in paged mode. A paged access returns `rsp_paged` high and `rsp_addr` equal to `req_addr`.
- R6: A user access (`req_user` high) to regions 0xB to 0xF returns `rsp_fault` high, `rsp_paged` low and `rsp_addr` zero. The fault takes precedence over paged mode.
- R7: A user access to regions 0x0 to 0xA is translated exactly as a kernel access is.
- R8: A kernel access never faults, whatever the region.
- R9: A write with select 3 changes no configuration.
- R10: A request in the same cycle as a configuration write is translated with the configuration held before that write. Later requests see the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | 0 mode, 1 low bases, 2 high bases, 3 unused |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Virtual address |
| req_user | input | 1 | High for an unprivileged access |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_addr | output | 32 | Physical address, or the virtual address when paged |
| rsp_paged | output | 1 | Route to page translation |
| rsp_fault | output | 1 | Access refused by the privilege fence |

## Verification
A configuration write and a translation request can arrive in the same cycle. The question is then which mapping the request sees. The bench provokes this by driving a base rewrite for region 4 together with a request to region 4. It expects the old base on that response and the new base on the request that follows. The scoreboard model updates its own configuration copy only after computing the expected result of the coincident request.

// File: rtl/kseg_xlate.sv
module kseg_xlate #(
  parameter int ADDR_W   = 32,
  parameter int SEG_BITS = 4,
  parameter int USER_TOP = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_paged,
  output logic              rsp_fault
);
  localparam int NSEG  = 1 << SEG_BITS;
  localparam int OFF_W = ADDR_W - SEG_BITS;
  localparam int HALF  = NSEG * SEG_BITS / 2;

  logic [NSEG-1:0]          mode_q;
  logic [HALF-1:0]          base_lo, base_hi;
  logic [2*HALF-1:0]        bases;
  logic [SEG_BITS-1:0]      seg, base;
  logic                     fence, paged;
  logic [ADDR_W-1:0]        xaddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      base_lo <= '0;
      base_hi <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: mode_q  <= cfg_wdata[NSEG-1:0];
        2'd1: base_lo <= cfg_wdata[HALF-1:0];
        2'd2: base_hi <= cfg_wdata[HALF-1:0];
        default: ;
      endcase
    end
  end

  assign bases = {base_hi, base_lo};
  assign seg   = req_addr[ADDR_W-1 -: SEG_BITS];
  assign base  = bases[seg*SEG_BITS +: SEG_BITS];
  assign fence = req_user && (int'(seg) > USER_TOP);
  assign paged = mode_q[seg];
  assign xaddr = fence ? '0 : paged ? req_addr : {base, req_addr[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_paged <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_paged <= req_valid && paged && !fence;
      rsp_fault <= req_valid && fence;
      if (req_valid) rsp_addr <= xaddr;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r6_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid && !rsp_paged && rsp_addr == '0);
  a_r8_fault_user_only: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> $past(req_user) && int'($past(req_addr[ADDR_W-1 -: SEG_BITS])) > USER_TOP);
  a_r5_paged_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_paged |-> rsp_addr == $past(req_addr));
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_addr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]));
endmodule

// File: tb/kseg_xlate_test.sv
module kseg_xlate_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_user = 1'b0;
  logic        rsp_valid, rsp_paged, rsp_fault;
  logic [31:0] rsp_addr;

  int checks = 0;
  int failures = 0;
  logic finished = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic        paged;
    logic        fault;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [15:0] m_mode = '0;
  logic [31:0] m_lo = '0, m_hi = '0;

  kseg_xlate uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_user(req_user), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_paged(rsp_paged), .rsp_fault(rsp_fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic exp_t model(input logic [31:0] a, input logic u, input string tag);
    exp_t e;
    logic [3:0] s;
    logic [3:0] b;
    s = a[31:28];
    b = (s < 8) ? m_lo[s*4 +: 4] : m_hi[(s-8)*4 +: 4];
    e.tag = tag;
    e.fault = u && s >= 4'hB;
    e.paged = !e.fault && m_mode[s];
    e.addr  = e.fault ? 32'h0 : e.paged ? a : {b, a[27:0]};
    return e;
  endfunction

  task automatic model_write(input logic [1:0] sel, input logic [31:0] d);
    case (sel)
      2'd0: m_mode = d[15:0];
      2'd1: m_lo = d;
      2'd2: m_hi = d;
      default: ;
    endcase
  endtask

  task automatic req(input logic [31:0] a, input logic u, input string tag);
    @(negedge clk);
    cfg_we = 1'b0;
    req_valid = 1'b1; req_addr = a; req_user = u;
    sb.push_back(model(a, u, tag));
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    model_write(sel, d);
  endtask

  task automatic wr_req(input logic [1:0] sel, input logic [31:0] d,
                        input logic [31:0] a, input logic u, input string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    req_valid = 1'b1; req_addr = a; req_user = u;
    sb.push_back(model(a, u, tag));
    model_write(sel, d);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2", "response without request", 32'h1, 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rsp_addr == e.addr, e.tag, "addr", rsp_addr, e.addr);
          check(rsp_paged == e.paged, e.tag, "paged", {31'b0, rsp_paged}, {31'b0, e.paged});
          check(rsp_fault == e.fault, e.tag, "fault", {31'b0, rsp_fault}, {31'b0, e.fault});
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(rsp_valid == 1'b0, "R1", "valid after reset", {31'b0, rsp_valid}, 32'h0);
    req(32'h7123_4567, 1'b0, "R1");
    req(32'hF000_0001, 1'b0, "R1");
    idle(2);

    wr(2'd1, 32'hC004_0009);
    wr(2'd2, 32'h0004_B300);
    wr(2'd0, 32'h0000_2004);
    idle(1);

    req(32'h4000_1234, 1'b0, "R3");
    req(32'h0000_0010, 1'b0, "R4");
    req(32'h7FFF_FFFF, 1'b0, "R4");
    req(32'hC012_3456, 1'b0, "R4");
    req(32'hA000_0004, 1'b1, "R7");
    req(32'hB800_0000, 1'b0, "R8");
    req(32'hFFFF_FFFF, 1'b0, "R8");
    idle(1);
    req(32'hD004_000C, 1'b0, "R5");
    req(32'h2ABC_0000, 1'b1, "R5");
    req(32'hB000_0000, 1'b1, "R6");
    req(32'hD004_000C, 1'b1, "R6");
    req(32'hFFFF_FFFF, 1'b1, "R6");
    req(32'h9123_0000, 1'b1, "R7");
    idle(2);

    wr(2'd3, 32'hFFFF_FFFF);
    req(32'h4000_0000, 1'b0, "R9");
    req(32'hD000_0000, 1'b0, "R9");
    idle(1);

    wr_req(2'd1, 32'hC001_0009, 32'h4000_0008, 1'b0, "R10");
    req(32'h4000_0008, 1'b0, "R10");
    wr_req(2'd0, 32'h0, 32'hD004_000C, 1'b0, "R10");
    req(32'hD004_000C, 1'b0, "R10");
    idle(3);

    check(sb.size() == 0, "R2", "outstanding responses", sb.size(), 32'h0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule